// File: doc/BRIEF.md
# M/N:D Fractional Clock Divider

This block derives a slower waveform from its input clock by a rational factor M/N. A phase accumulator advances by M on every input cycle and wraps at N. Over one window of N input cycles it therefore produces M output pulses, and a separate duty value sets how many of those N cycles the output is high. The output `clk_div_o` is a registered waveform at input-cycle resolution. When the block is in pass-through it is held high, which tells a downstream clock gate to pass the input clock unchanged.

The three configuration words use the encodings a control register file would hold. M is taken directly. The N word holds the bitwise inverse of N−M, and the D word holds the bitwise inverse of twice the duty count. The block decodes these words, clamps the duty to a range that keeps the waveform alive, and reports the effective ratio and duty on read-back ports. A two-bit mode selects pass-through or fractional operation.

Any change to the configuration restarts the phase from zero, so a new setting starts from a known point.

Top module: `mnd_frac_div`

## Requirements
- R1: While `rst_ni` is low, `clk_div_o` is 0.
- R2: In fractional operation, `ratio_m_o` equals `m_reg_i`, and `ratio_n_o` equals (bitwise inverse of `n_reg_i`, masked to WIDTH bits) plus `m_reg_i`, computed in WIDTH+1 bits.
- R3: With `mode_i` = 0 (pass-through), the values of M, N and D have no effect. `ratio_m_o` = 1, `ratio_n_o` = 1, `duty_o` = 1, and `clk_div_o` is 1 on every cycle from the cycle after the configuration is applied.
- R4: When `m_reg_i`, `n_reg_i` and `d_reg_i` are all 0, the block behaves as pass-through, as in R3, for any value of `mode_i`.
- R5: When `n_reg_i` is all ones (so N−M = 0, meaning N equals M), the block behaves as pass-through, as in R3.
- R6: The requested double-duty is 2d = inverse of `d_reg_i`, masked to WIDTH bits. It is first raised to max(M,1) if below that value, then lowered to 2·(N−M) if above it, so the upper bound wins. `duty_o` is half the clamped value, rounded up, so it is never 0 when M is not 0.
- R7: A change on any configuration input, or the first cycle after reset, restarts the phase. In the next cycle the accumulator is 0 and, in fractional operation with M ≠ 0, `clk_div_o` is 1.
- R8: In fractional operation, `clk_div_o` is 1 exactly when the accumulator value is below the duty d. Over the N cycles that start at a restart, it is therefore high for g·ceil(d/g) cycles, where g = gcd(M,N).
- R9: Over those N cycles, counting the restart cycle as a rising edge, `clk_div_o` shows exactly M rising edges whenever d ≥ M.
- R10: In fractional operation with M = 0, `clk_div_o` stays 0, `duty_o` is 0 and `ratio_m_o` is 0.
- R11: The mode values 1, 2 and 3 all select fractional operation with identical behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_reg_i | input | WIDTH | M value, stored directly |
| n_reg_i | input | WIDTH | Inverse of N−M |
| d_reg_i | input | WIDTH | Inverse of twice the duty count |
| mode_i | input | 2 | 0 selects pass-through; any other value selects fractional operation |
| clk_div_o | output | 1 | Divided waveform, registered |
| ratio_m_o | output | WIDTH | Effective M |
| ratio_n_o | output | WIDTH+1 | Effective N |
| duty_o | output | WIDTH | Effective high count per N cycles |

## Verification
The bench runs a 4-bit instance and sweeps every M against every nonzero N−M. Each pair is tried with three D words. The first asks for the widest duty and so exercises the upper clamp. The second asks for zero and exercises the lower clamp. The third asks for a mid value that passes through unclamped.

Counting high cycles over a full N-cycle window separates correct phase stepping from wrong wrap arithmetic, and coprime M/N pairs are distinguished from pairs with a common factor. Counting rising edges separates a true M-pulse pattern from a merged or missing pulse. Pass-through is reached by three routes, the mode, all-zero registers and N equal to M, each with random register contents, to show that the other fields are ignored.

// File: rtl/mnd_div_pkg.sv
package mnd_div_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ALT1 = 2'd1,
    MODE_DUAL = 2'd2,
    MODE_ALT3 = 2'd3
  } mnd_mode_e;

endpackage

// File: rtl/mnd_cfg_decode.sv
module mnd_cfg_decode
  import mnd_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] m_reg_i,
  input  logic [WIDTH-1:0] n_reg_i,
  input  logic [WIDTH-1:0] d_reg_i,
  input  logic [1:0]       mode_i,
  output logic             active_o,
  output logic [WIDTH-1:0] m_o,
  output logic [WIDTH:0]   n_o,
  output logic [WIDTH-1:0] span_o,
  output logic [WIDTH-1:0] duty_o
);
  localparam int NW = WIDTH + 1;

  mnd_mode_e       mode;
  logic [WIDTH-1:0] span;
  logic [NW-1:0]    n_full;
  logic             all_zero;
  logic [WIDTH-1:0] dbl_req;
  logic [NW-1:0]    lo_bound, hi_bound, dbl_clamp, dbl_round;
  logic [WIDTH-1:0] duty_raw;

  assign mode     = mnd_mode_e'(mode_i);
  assign span     = ~n_reg_i;
  assign n_full   = {1'b0, span} + {1'b0, m_reg_i};
  assign all_zero = (m_reg_i == '0) && (n_reg_i == '0) && (d_reg_i == '0);
  assign active_o = (mode != MODE_PASS) && !all_zero && (span != '0);

  assign dbl_req  = ~d_reg_i;
  assign lo_bound = (m_reg_i == '0) ? NW'(1) : {1'b0, m_reg_i};
  assign hi_bound = {span, 1'b0};

  // upper bound applied last so it wins when bounds cross
  always_comb begin
    dbl_clamp = {1'b0, dbl_req};
    if (dbl_clamp < lo_bound) dbl_clamp = lo_bound;
    if (dbl_clamp > hi_bound) dbl_clamp = hi_bound;
  end

  assign dbl_round = dbl_clamp + NW'(1);
  assign duty_raw  = dbl_round[NW-1:1];

  assign span_o = span;
  assign m_o    = active_o ? m_reg_i : WIDTH'(1);
  assign n_o    = active_o ? n_full  : NW'(1);
  assign duty_o = !active_o ? WIDTH'(1) : ((m_reg_i == '0) ? '0 : duty_raw);

endmodule

// File: rtl/mnd_phase_acc.sv
module mnd_phase_acc #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3*WIDTH+1:0] cfg_i,
  input  logic             active_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic [WIDTH:0]   n_i,
  input  logic [WIDTH-1:0] duty_i,
  output logic             restart_o,
  output logic             out_o
);
  localparam int NW = WIDTH + 1;
  localparam int CW = 3 * WIDTH + 2;

  logic [NW-1:0] acc_q, acc_nxt;
  logic [NW:0]   sum;
  logic [CW-1:0] cfg_q;
  logic          primed_q, out_q;

  assign restart_o = !primed_q || (cfg_i != cfg_q);
  assign sum       = {1'b0, acc_q} + {2'b0, m_i};
  assign acc_nxt   = (sum >= {1'b0, n_i}) ? NW'(sum - {1'b0, n_i}) : NW'(sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      out_q    <= 1'b0;
      cfg_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      cfg_q    <= cfg_i;
      if (restart_o || !active_i) begin
        acc_q <= '0;
        out_q <= !active_i || (m_i != '0);
      end else begin
        acc_q <= acc_nxt;
        out_q <= (m_i != '0) && (acc_nxt < {1'b0, duty_i});
      end
    end
  end

  assign out_o = out_q;

  p_acc_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !restart_o) |-> (acc_q < n_i));

  p_restart_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o && active_i && (m_i != '0)) |=> (out_q && (acc_q == '0)));

endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] m_reg_i,
  input  logic [WIDTH-1:0] n_reg_i,
  input  logic [WIDTH-1:0] d_reg_i,
  input  logic [1:0]       mode_i,
  output logic             clk_div_o,
  output logic [WIDTH-1:0] ratio_m_o,
  output logic [WIDTH:0]   ratio_n_o,
  output logic [WIDTH-1:0] duty_o
);
  localparam int CW = 3 * WIDTH + 2;

  logic             active;
  logic [WIDTH-1:0] m_eff, span, duty;
  logic [WIDTH:0]   n_eff;
  logic [CW-1:0]    cfg;
  logic             restart;

  assign cfg = {mode_i, d_reg_i, n_reg_i, m_reg_i};

  mnd_cfg_decode #(.WIDTH(WIDTH)) u_decode (
    .m_reg_i (m_reg_i),
    .n_reg_i (n_reg_i),
    .d_reg_i (d_reg_i),
    .mode_i  (mode_i),
    .active_o(active),
    .m_o     (m_eff),
    .n_o     (n_eff),
    .span_o  (span),
    .duty_o  (duty)
  );

  mnd_phase_acc #(.WIDTH(WIDTH)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .active_i (active),
    .m_i      (m_eff),
    .n_i      (n_eff),
    .duty_i   (duty),
    .restart_o(restart),
    .out_o    (clk_div_o)
  );

  assign ratio_m_o = m_eff;
  assign ratio_n_o = n_eff;
  assign duty_o    = duty;

  p_pass_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !restart) |-> clk_div_o);

  p_zero_m_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && (m_reg_i == '0) && !restart) |-> !clk_div_o);

  p_duty_bounds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && (m_reg_i != '0)) |-> ((duty != '0) && (duty <= span)));

  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !clk_div_o);

endmodule

// File: tb/mnd_frac_div_tb.sv
module mnd_frac_div_tb;
  localparam int  W        = 4;
  localparam int  MASK     = (1 << W) - 1;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [W-1:0] m_reg, n_reg, d_reg;
  logic [1:0]   mode;
  logic         clk_div;
  logic [W-1:0] ratio_m, duty;
  logic [W:0]   ratio_n;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  mnd_frac_div #(.WIDTH(W)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .m_reg_i  (m_reg),
    .n_reg_i  (n_reg),
    .d_reg_i  (d_reg),
    .mode_i   (mode),
    .clk_div_o(clk_div),
    .ratio_m_o(ratio_m),
    .ratio_n_o(ratio_n),
    .duty_o   (duty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (m=%0d nreg=%0d dreg=%0d mode=%0d)",
               req, act, exp, m_reg, n_reg, d_reg, mode);
    end
  endtask

  function automatic int gcd(input int a, input int b);
    int x = a, y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic run_vec(input int m, input int nr, input int dr, input int md);
    int span, nn, d2, lo, hi, t, dexp, len, g, hi_exp, highs, rises;
    bit all0, act, prev;
    string tag;
    span = (~nr) & MASK;
    nn   = span + m;
    all0 = (m == 0) && (nr == 0) && (dr == 0);
    act  = (md != 0) && !all0 && (span != 0);
    d2   = (~dr) & MASK;
    lo   = (m == 0) ? 1 : m;
    hi   = 2 * span;
    t    = (d2 < lo) ? lo : d2;
    t    = (t > hi) ? hi : t;
    dexp = !act ? 1 : ((m == 0) ? 0 : (t + 1) / 2);
    tag  = (md == 0) ? "R3" : (all0 ? "R4" : ((span == 0) ? "R5" : ((md != 2) ? "R11" : "R2")));

    @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    m_reg = W'(m); n_reg = W'(nr); d_reg = W'(dr); mode = 2'(md);
    #1;
    check(ratio_m == W'(act ? m : 1), tag, int'(ratio_m), act ? m : 1);
    check(ratio_n == (W+1)'(act ? nn : 1), tag, int'(ratio_n), act ? nn : 1);
    check(duty == W'(dexp), (act && m == 0) ? "R10" : "R6", int'(duty), dexp);
    @(negedge clk);

    len   = act ? nn : 4;
    highs = 0;
    rises = 0;
    prev  = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (k == 0 && act && m != 0) check(clk_div == 1'b1, "R7", int'(clk_div), 1);
      if (clk_div) highs++;
      if (clk_div && !prev) rises++;
      prev = clk_div;
      @(negedge clk);
    end

    if (!act) begin
      check(highs == len, tag, highs, len);
    end else if (m == 0) begin
      check(highs == 0, "R10", highs, 0);
    end else begin
      g      = gcd(m, nn);
      hi_exp = g * ((dexp + g - 1) / g);
      check(highs == hi_exp, (md != 2) ? "R8 R11" : "R8", highs, hi_exp);
      if (dexp >= m) check(rises == m, "R9", rises, m);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    m_reg = '0; n_reg = '0; d_reg = '0; mode = 2'd2;
    repeat (3) @(negedge clk);
    check(clk_div == 1'b0, "R1", int'(clk_div), 0);
    rst_ni = 1'b1;

    for (int m = 0; m <= MASK; m++) begin
      for (int sp = 1; sp <= MASK; sp++) begin
        int nr = (~sp) & MASK;
        int md = (m % 3) + 1;
        run_vec(m, nr, 0, md);
        run_vec(m, nr, MASK, md);
        run_vec(m, nr, (~sp) & MASK, md);
      end
    end

    for (int i = 0; i < 16; i++) begin
      run_vec($urandom_range(0, MASK), $urandom_range(0, MASK), $urandom_range(0, MASK), 0);
      run_vec($urandom_range(0, MASK), MASK, $urandom_range(0, MASK), $urandom_range(1, 3));
    end
    run_vec(0, 0, 0, 2);
    run_vec(0, 0, 0, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule